// File: doc/BRIEF.md
# Decode-Stage VL Read Rewrite

This block sits in the decode stage of a scalar core that uses one of its 32 general registers as the vector length. It keeps a 5-bit alias that names that register. Each decoded instruction passes through the block. When the instruction is a plain read of the vector-length CSR and the alias names a register other than x0, the block swaps it for `ADDI rd, alias, 0`. The result is a register-to-register move into the same destination. The move then goes through ordinary scalar dependency tracking, so the core needs no CSR hazard logic and no stall for that read.

The execute stage loads the alias by pulsing a setvl notification that carries the destination register of the executed setvl. An update and a matching read in the same cycle see the new alias. The alias logic is a two-state machine. `ALIAS_NONE` means the alias is x0 and nothing is rewritten. `ALIAS_LIVE` means a non-zero register is bound. There are three transitions: BIND (NONE to LIVE, on a setvl with a non-zero register), UNBIND (LIVE to NONE, on a setvl with register 0) and REBIND (LIVE to LIVE, on a setvl with another non-zero register). The instruction path is purely combinational and adds no cycle.

Top module: `vl_alias_rewrite`

## Requirements
- R1: After reset the alias is x0. A VL CSR read presented before any setvl leaves the block unchanged, with `out_rewritten` low.
- R2: A VL CSR read meets the alias when it is valid, non-zero and taken. A VL CSR read is opcode 7'b1110011 (bits 6:0), funct3 3'b010 (bits 14:12), rs1 = 0 (bits 19:15) and CSR field (bits 31:20) equal to `VL_CSR_ADDR`. Such a read leaves as `{12'h000, alias, 3'b000, rd, 7'b0010011}`, where rd is the incoming bits 11:7.
- R3: An instruction whose CSR field differs from `VL_CSR_ADDR`, or that is not a system opcode, passes through unchanged.
- R4: A system instruction with the VL address passes through unchanged in two cases: funct3 is not 3'b010, or rs1 is non-zero.
- R5: While the alias is x0, a VL CSR read passes through unchanged.
- R6: On a clock edge with `setvl_valid` high, the alias takes `setvl_rd`. `setvl_rd` = 0 disables rewriting.
- R7: A setvl notification and a VL CSR read in the same cycle use the newly supplied `setvl_rd` as the alias.
- R8: `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in the same cycle.
- R9: `out_rewritten` is high exactly when `in_valid` is high and the instruction is being substituted.
- R10: Without `setvl_valid`, the alias holds its value across cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the alias to x0 |
| setvl_valid | input | 1 | Execute stage reports a setvl this cycle |
| setvl_rd | input | 5 | Register that now holds the vector length |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Downstream can accept |
| in_instr | input | 32 | Decoded instruction word |
| out_valid | output | 1 | Instruction forwarded |
| out_ready | input | 1 | Downstream ready |
| out_instr | output | 32 | Original or substituted instruction |
| out_rewritten | output | 1 | Substitution took place |

## Verification
The alias update and the CSR-read rewrite can fall in the same cycle. A read issued alongside a setvl must use the incoming register, not the stored one. The bench provokes this with directed cycles and with random traffic where setvl pulses overlap VL reads, including pulses that bind to x0. It judges each cycle against a behavioural model that applies the pending setvl before forming the expected word, then commits the alias after the edge.

// File: rtl/vl_alias_pkg.sv
package vl_alias_pkg;
    localparam int REG_IDX_W  = 5;
    localparam int INSTR_W    = 32;
    localparam int CSR_ADDR_W = 12;
    localparam int FUNCT3_W   = 3;
    localparam int OPC_W      = 7;

    localparam logic [OPC_W-1:0]    OPC_SYSTEM = 7'b1110011;
    localparam logic [OPC_W-1:0]    OPC_OP_IMM = 7'b0010011;
    localparam logic [FUNCT3_W-1:0] F3_CSR_SET = 3'b010;
    localparam logic [FUNCT3_W-1:0] F3_ADDI    = 3'b000;

    typedef logic [REG_IDX_W-1:0] reg_idx_t;

    typedef enum logic [0:0] {
        ALIAS_NONE = 1'b0,
        ALIAS_LIVE = 1'b1
    } alias_state_t;

    typedef struct packed {
        logic [CSR_ADDR_W-1:0] imm;
        reg_idx_t              rs1;
        logic [FUNCT3_W-1:0]   f3;
        reg_idx_t              rd;
        logic [OPC_W-1:0]      opc;
    } itype_t;
endpackage

// File: rtl/vl_alias_track.sv
module vl_alias_track
    import vl_alias_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     setvl_valid,
    input  reg_idx_t setvl_rd,
    output reg_idx_t alias_eff,
    output logic     alias_live
);
    alias_state_t state_q, state_d;
    reg_idx_t     alias_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ALIAS_NONE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           alias_q <= '0;
        else if (setvl_valid) alias_q <= setvl_rd;
    end

    // Transitions: BIND, UNBIND, REBIND
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ALIAS_NONE: if (setvl_valid && setvl_rd != '0) state_d = ALIAS_LIVE;
            ALIAS_LIVE: if (setvl_valid && setvl_rd == '0) state_d = ALIAS_NONE;
            default:    state_d = ALIAS_NONE;
        endcase
    end

    // Outputs forward a same-cycle notification (R7)
    always_comb begin
        if (setvl_valid) begin
            alias_eff  = setvl_rd;
            alias_live = (setvl_rd != '0);
        end else begin
            alias_eff  = alias_q;
            alias_live = (state_q == ALIAS_LIVE);
        end
    end

    a_r6_alias_load: assert property (@(posedge clk) disable iff (!rst_n)
        setvl_valid |=> alias_q == $past(setvl_rd));
    a_r10_alias_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !setvl_valid |=> $stable(alias_q));
    a_r5_none_is_x0: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ALIAS_NONE) |-> (alias_q == '0));
    a_r6_live_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ALIAS_LIVE) |-> (alias_q != '0));
endmodule

// File: rtl/vl_csr_match.sv
module vl_csr_match
    import vl_alias_pkg::*;
#(
    parameter logic [CSR_ADDR_W-1:0] VL_CSR_ADDR = 12'hC20
) (
    input  logic [CSR_ADDR_W-1:0] csr,
    input  reg_idx_t              rs1,
    input  logic [FUNCT3_W-1:0]   f3,
    input  logic [OPC_W-1:0]      opc,
    output logic                  is_vl_read
);
    always_comb begin
        is_vl_read = (opc == OPC_SYSTEM) && (f3 == F3_CSR_SET)
                  && (rs1 == '0) && (csr == VL_CSR_ADDR);
    end
endmodule

// File: rtl/vl_move_build.sv
module vl_move_build
    import vl_alias_pkg::*;
(
    input  itype_t   in_word,
    input  logic     do_swap,
    input  reg_idx_t alias_reg,
    output itype_t   out_word
);
    always_comb begin
        if (do_swap) begin
            out_word.imm = '0;
            out_word.rs1 = alias_reg;
            out_word.f3  = F3_ADDI;
            out_word.rd  = in_word.rd;
            out_word.opc = OPC_OP_IMM;
        end else begin
            out_word = in_word;
        end
    end
endmodule

// File: rtl/vl_alias_rewrite.sv
module vl_alias_rewrite
    import vl_alias_pkg::*;
#(
    parameter logic [CSR_ADDR_W-1:0] VL_CSR_ADDR = 12'hC20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               setvl_valid,
    input  logic [4:0]         setvl_rd,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [INSTR_W-1:0] in_instr,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [INSTR_W-1:0] out_instr,
    output logic               out_rewritten
);
    itype_t   in_word, out_word;
    reg_idx_t alias_eff;
    logic     alias_live;
    logic     is_vl_read;
    logic     do_swap;

    assign in_word = itype_t'(in_instr);

    vl_alias_track u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .setvl_valid(setvl_valid),
        .setvl_rd   (setvl_rd),
        .alias_eff  (alias_eff),
        .alias_live (alias_live)
    );

    vl_csr_match #(.VL_CSR_ADDR(VL_CSR_ADDR)) u_match (
        .csr       (in_word.imm),
        .rs1       (in_word.rs1),
        .f3        (in_word.f3),
        .opc       (in_word.opc),
        .is_vl_read(is_vl_read)
    );

    assign do_swap = is_vl_read && alias_live;

    vl_move_build u_build (
        .in_word  (in_word),
        .do_swap  (do_swap),
        .alias_reg(alias_eff),
        .out_word (out_word)
    );

    always_comb begin
        out_instr     = out_word;
        out_valid     = in_valid;
        in_ready      = out_ready;
        out_rewritten = in_valid && do_swap;
    end

    a_r8_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid == in_valid) && (in_ready == out_ready));
    a_r9_flag_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_rewritten |-> out_valid);
    a_r3_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_rewritten) |-> (out_instr == in_instr));
    a_r2_move_shape: assert property (@(posedge clk) disable iff (!rst_n)
        out_rewritten |-> (out_instr[6:0] == 7'b0010011 && out_instr[14:12] == 3'b000
                           && out_instr[11:7] == in_instr[11:7] && out_instr[31:20] == 12'h000
                           && out_instr[19:15] != 5'd0));
endmodule

// File: tb/vl_alias_rewrite_bench.sv
module vl_alias_rewrite_bench;
    localparam logic [11:0] VLA = 12'hC20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        setvl_valid = 1'b0;
    logic [4:0]  setvl_rd = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_instr = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_instr;
    logic        out_rewritten;

    int compared = 0;
    int mismatched = 0;
    int model_alias = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vl_alias_rewrite #(.VL_CSR_ADDR(VLA)) u_vl_alias_rewrite (
        .clk(clk), .rst_n(rst_n), .setvl_valid(setvl_valid), .setvl_rd(setvl_rd),
        .in_valid(in_valid), .in_ready(in_ready), .in_instr(in_instr),
        .out_valid(out_valid), .out_ready(out_ready), .out_instr(out_instr),
        .out_rewritten(out_rewritten)
    );

    function automatic logic [31:0] csr_op(input int f3, input int rs1, input int rd, input logic [11:0] csr);
        return {csr, rs1[4:0], f3[2:0], rd[4:0], 7'b1110011};
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic step(input string tag, input bit sv, input int srd, input bit iv, input bit ordy,
                        input logic [31:0] ins);
        int  eff;
        bit  vlr;
        logic [31:0] exp;
        string t;
        @(negedge clk);
        setvl_valid = sv; setvl_rd = srd[4:0]; in_valid = iv; out_ready = ordy; in_instr = ins;
        #1;
        eff = sv ? srd : model_alias;
        vlr = (ins[6:0] == 7'b1110011) && (ins[14:12] == 3'b010) && (ins[19:15] == 0) && (ins[31:20] == VLA);
        if (vlr && eff != 0) exp = {12'h000, eff[4:0], 3'b000, ins[11:7], 7'b0010011};
        else                 exp = ins;
        t = tag;
        if (t == "") t = (vlr && eff != 0) ? "R2" : (vlr ? "R5" : "R3");
        chk("R8 out_valid", {31'd0, out_valid}, {31'd0, iv});
        chk("R8 in_ready", {31'd0, in_ready}, {31'd0, ordy});
        chk("R9 out_rewritten", {31'd0, out_rewritten}, {31'd0, iv && vlr && eff != 0});
        if (iv) chk(t, out_instr, exp);
        if (sv) model_alias = srd;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset out_rewritten", {31'd0, out_rewritten}, 32'd0);
        rst_n = 1'b1;
        step("R1", 0, 0, 1, 1, csr_op(2, 0, 5, VLA));
        step("R6", 1, 7, 0, 1, 32'h0);
        step("R2", 0, 0, 1, 1, csr_op(2, 0, 3, VLA));
        step("R3", 0, 0, 1, 0, csr_op(2, 0, 3, VLA + 12'd1));
        step("R3", 0, 0, 1, 1, 32'h00A28293);
        step("R4", 0, 0, 1, 1, csr_op(1, 0, 3, VLA));
        step("R4", 0, 0, 1, 1, csr_op(2, 4, 3, VLA));
        step("R4", 0, 0, 1, 1, csr_op(6, 0, 3, VLA));
        for (int i = 0; i < 4; i++) step("R10", 0, 0, 1, 1, csr_op(2, 0, i + 10, VLA));
        step("R7", 1, 9, 1, 1, csr_op(2, 0, 12, VLA));
        step("R6", 0, 0, 1, 1, csr_op(2, 0, 0, VLA));
        step("R7", 1, 0, 1, 1, csr_op(2, 0, 12, VLA));
        step("R5", 0, 0, 1, 1, csr_op(2, 0, 13, VLA));
        step("R7", 1, 31, 1, 1, csr_op(2, 0, 1, VLA));
        for (int i = 0; i < 600; i++) begin
            int k;
            logic [31:0] w;
            k = $urandom_range(0, 3);
            case (k)
                0: w = csr_op(2, 0, $urandom_range(0, 31), VLA);
                1: w = csr_op(2, 0, $urandom_range(0, 31), 12'($urandom));
                2: w = $urandom;
                default: w = csr_op($urandom_range(0, 7), $urandom_range(0, 3), $urandom_range(0, 31), VLA);
            endcase
            step("", ($urandom_range(0, 3) == 0), ($urandom_range(0, 4) == 0) ? 0 : $urandom_range(1, 31),
                 $urandom_range(0, 1), $urandom_range(0, 1), w);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule